// File: doc/BRIEF.md
# Coherent Cache Line Request Controller

This block owns the coherence state of a single cache line on the processor side of a five-state ownership protocol. The states are Invalid, Shared, Exclusive, Owned and Modified. Local events arrive one at a time: load, instruction fetch, store, atomic and ownership prefetch, each optionally flagged as a victimization of the current line. The block decides whether the event needs a system transaction. If it does, it emits a one-cycle request strobe and then waits for a one-cycle reply strobe. The code of that reply sets the final line state.

Only one transaction can be outstanding. While it is open the `busy` output is high, and local events presented in that time are dropped, so the requester must present them again. The snoop handler on the system side can also rewrite the line state through a separate update port while the block is idle. This is how Owned or a downgraded state is reached. If a reply does not fit the open request, or arrives when nothing is open, the block pulses an error flag and leaves the line state as it was. A cancelled writeback pulses a drop strobe so that the data path discards the pending write data.

Top module: `cohLineReq`

## Requirements
- R1: After reset the line state is Invalid (3'b000), `busy` is low, and no request, error or drop strobe is active.
- R2: A load on an Invalid line issues a shared-read request (`reqOut` = 4'b0001). Reply 5'b00001 (unique data) makes the line Exclusive (3'b010). Reply 5'b00010 (shared data) makes it Shared (3'b001).
- R3: An instruction fetch on an Invalid line issues a shared-always read request (4'b0010). The only accepted reply is shared data, and it makes the line Shared.
- R4: A store, atomic or ownership prefetch on an Invalid line issues a read-for-ownership request (4'b0100). A unique-data reply makes the line Modified (3'b100).
- R5: A store or atomic on an Exclusive line makes the line Modified on the next cycle. No request is issued and `busy` stays low.
- R6: A store, atomic or ownership prefetch on a Shared or Owned (3'b011) line issues a read-for-ownership request. Only the ownership acknowledge (5'b00100) is accepted, and it makes the line Modified.
- R7: A victimizing event on a clean line (Shared or Exclusive) sets the line Invalid at once, with no writeback. In the same cycle the block issues the miss request that the event's kind calls for on an Invalid line.
- R8: A victimizing event on a Modified or Owned line issues a writeback request (4'b1000). A writeback acknowledge (5'b01000) leaves the line Invalid.
- R9: A writeback-cancel reply (5'b10000) leaves the line Invalid and pulses `wbDrop` for exactly one cycle. The writeback request is not issued again.
- R10: `busy` is high from the cycle the request strobe appears until the cycle after the closing reply. Events presented while `busy` is high produce no request and no state change, including an event presented in the same cycle as the closing reply.
- R11: A reply that does not fit the open request, or any reply while idle, pulses `protoErr` for one cycle. The line state is unchanged, and an open transaction stays open.
- R12: Events that need no transaction and no state change leave the state unchanged and issue nothing. These are loads and fetches on a valid line, stores and atomics on Modified, and ownership prefetches on Exclusive or Modified.
- R13: While idle, a snoop update writes its state code into the line. A local event in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtValid | input | 1 | Local event strobe |
| evtKind | input | 3 | Event kind: 0 load, 1 fetch, 2 store, 3 atomic, 4 ownership prefetch |
| evtVictim | input | 1 | Event replaces (victimizes) the current line |
| snpValid | input | 1 | Snoop-side state update strobe |
| snpState | input | 3 | State code written by the snoop update |
| rspIn | input | 5 | One-hot reply: unique data, shared data, ownership ack, writeback ack, writeback cancel (bits 0..4) |
| reqOut | output | 4 | One-hot request: shared read, shared-always read, read-for-ownership, writeback (bits 0..3) |
| busy | output | 1 | Transaction outstanding |
| lineState | output | 3 | Current line state code |
| protoErr | output | 1 | One-cycle pulse on an unexpected reply |
| wbDrop | output | 1 | One-cycle pulse: discard the cancelled writeback data |

## Verification
Two pairs of inputs can meet in one cycle. The first pair is the reply that closes a transaction and a new local event. The bench presents a store in the same cycle as the shared-data reply to a pending load and expects the line to end Shared, with no read-for-ownership in the request stream. The second pair is a snoop update and a local store on an idle line. The bench expects the snoop's code to win and no Modified state to follow. A scoreboard queue holds the requests each stimulus should cause, and any extra or missing request counts as a miscompare.

// File: rtl/cohLineReqPkg.sv
package cohLineReqPkg;
  localparam int STATE_W = 3;
  localparam int KIND_W  = 3;
  localparam int REQ_W   = 4;
  localparam int RSP_W   = 5;

  typedef enum logic [STATE_W-1:0] {
    ST_I = 3'b000, ST_S = 3'b001, ST_E = 3'b010, ST_O = 3'b011, ST_M = 3'b100
  } lineSt_e;

  typedef enum logic [KIND_W-1:0] {
    EV_LOAD = 3'd0, EV_FETCH = 3'd1, EV_STORE = 3'd2, EV_ATOMIC = 3'd3, EV_PREFOWN = 3'd4
  } evtKind_e;

  localparam logic [REQ_W-1:0] REQ_RDS  = 4'b0001;
  localparam logic [REQ_W-1:0] REQ_RDSA = 4'b0010;
  localparam logic [REQ_W-1:0] REQ_RDO  = 4'b0100;
  localparam logic [REQ_W-1:0] REQ_WB   = 4'b1000;

  localparam logic [RSP_W-1:0] RSP_UNIQ = 5'b00001;
  localparam logic [RSP_W-1:0] RSP_SHR  = 5'b00010;
  localparam logic [RSP_W-1:0] RSP_OAK  = 5'b00100;
  localparam logic [RSP_W-1:0] RSP_WACK = 5'b01000;
  localparam logic [RSP_W-1:0] RSP_WCAN = 5'b10000;

  typedef enum logic [2:0] {
    PD_IDLE, PD_RDS, PD_RDSA, PD_RDOMISS, PD_RDOUPG, PD_WB
  } pend_e;

  typedef struct packed {
    logic             stateWe;
    lineSt_e          stateNext;
    logic [REQ_W-1:0] req;
    logic             err;
    logic             drop;
  } ctlStb_t;
endpackage

// File: rtl/cohLineReqCtl.sv
module cohLineReqCtl
  import cohLineReqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             evtValid,
  input  logic [KIND_W-1:0] evtKind,
  input  logic             evtVictim,
  input  logic             snpValid,
  input  logic [STATE_W-1:0] snpState,
  input  logic [RSP_W-1:0] rspIn,
  input  lineSt_e          curState,
  output ctlStb_t          stb,
  output logic             busy
);
  pend_e   pend, pendNext;
  lineSt_e effState;
  lineSt_e rspState;
  logic    rspOk;
  logic    isDirty, isClean;

  assign busy    = (pend != PD_IDLE);
  assign isDirty = (curState == ST_M) || (curState == ST_O);
  assign isClean = (curState == ST_E) || (curState == ST_S);

  // reply matching against the open request
  always_comb begin
    rspOk    = 1'b0;
    rspState = curState;
    case (pend)
      PD_RDS: begin
        if (rspIn == RSP_UNIQ) begin rspOk = 1'b1; rspState = ST_E; end
        else if (rspIn == RSP_SHR) begin rspOk = 1'b1; rspState = ST_S; end
      end
      PD_RDSA:    if (rspIn == RSP_SHR)  begin rspOk = 1'b1; rspState = ST_S; end
      PD_RDOMISS: if (rspIn == RSP_UNIQ) begin rspOk = 1'b1; rspState = ST_M; end
      PD_RDOUPG:  if (rspIn == RSP_OAK)  begin rspOk = 1'b1; rspState = ST_M; end
      PD_WB: begin
        if ((rspIn == RSP_WACK) || (rspIn == RSP_WCAN)) begin rspOk = 1'b1; rspState = ST_I; end
      end
      default: ;
    endcase
  end

  always_comb begin
    stb       = '0;
    stb.stateNext = curState;
    pendNext  = pend;
    effState  = (evtVictim && isClean) ? ST_I : curState;
    if (busy) begin
      if (rspIn != '0) begin
        if (rspOk) begin
          stb.stateWe   = 1'b1;
          stb.stateNext = rspState;
          stb.drop      = (rspIn == RSP_WCAN);
          pendNext      = PD_IDLE;
        end else begin
          stb.err = 1'b1;
        end
      end
    end else begin
      stb.err = (rspIn != '0);
      if (snpValid) begin
        if (snpState <= 3'b100) begin
          stb.stateWe   = 1'b1;
          stb.stateNext = lineSt_e'(snpState);
        end
      end else if (evtValid) begin
        if (evtVictim && isDirty) begin
          stb.req  = REQ_WB;
          pendNext = PD_WB;
        end else begin
          if (evtVictim && isClean) begin
            stb.stateWe   = 1'b1;
            stb.stateNext = ST_I;
          end
          case (evtKind_e'(evtKind))
            EV_LOAD: if (effState == ST_I) begin stb.req = REQ_RDS; pendNext = PD_RDS; end
            EV_FETCH: if (effState == ST_I) begin stb.req = REQ_RDSA; pendNext = PD_RDSA; end
            EV_STORE, EV_ATOMIC: begin
              if (effState == ST_I) begin stb.req = REQ_RDO; pendNext = PD_RDOMISS; end
              else if (effState == ST_E) begin stb.stateWe = 1'b1; stb.stateNext = ST_M; end
              else if ((effState == ST_S) || (effState == ST_O)) begin
                stb.req = REQ_RDO; pendNext = PD_RDOUPG;
              end
            end
            EV_PREFOWN: begin
              if (effState == ST_I) begin stb.req = REQ_RDO; pendNext = PD_RDOMISS; end
              else if ((effState == ST_S) || (effState == ST_O)) begin
                stb.req = REQ_RDO; pendNext = PD_RDOUPG;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pend <= PD_IDLE;
    else       pend <= pendNext;
  end

  // R10: nothing new leaves while a transaction is open
  p_quiet_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (stb.req == '0));
  // R11: a rejected reply never writes the line
  p_err_nowrite_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && stb.err) |-> !stb.stateWe);
endmodule

// File: rtl/cohLineReqDp.sv
module cohLineReqDp
  import cohLineReqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStb_t          stb,
  input  logic             busy,
  output lineSt_e          lineSt,
  output logic [REQ_W-1:0] reqOut,
  output logic             protoErr,
  output logic             wbDrop
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineSt   <= ST_I;
      reqOut   <= '0;
      protoErr <= 1'b0;
      wbDrop   <= 1'b0;
    end else begin
      if (stb.stateWe) lineSt <= stb.stateNext;
      reqOut   <= stb.req;
      protoErr <= stb.err;
      wbDrop   <= stb.drop;
    end
  end

  // R10: at most one request strobe, and it opens a transaction
  p_req_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqOut));
  p_req_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqOut != '0) |-> busy);
  // R9: a cancelled writeback leaves the line Invalid
  p_cancel_inv_r9: assert property (@(posedge clk) disable iff (!rstN)
    wbDrop |-> (lineSt == ST_I));
  // R11: an error during an open transaction keeps the state
  p_err_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (protoErr && $past(busy)) |-> $stable(lineSt));
endmodule

// File: rtl/cohLineReq.sv
module cohLineReq
  import cohLineReqPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               evtValid,
  input  logic [KIND_W-1:0]  evtKind,
  input  logic               evtVictim,
  input  logic               snpValid,
  input  logic [STATE_W-1:0] snpState,
  input  logic [RSP_W-1:0]   rspIn,
  output logic [REQ_W-1:0]   reqOut,
  output logic               busy,
  output logic [STATE_W-1:0] lineState,
  output logic               protoErr,
  output logic               wbDrop
);
  ctlStb_t stb;
  lineSt_e lineSt;

  cohLineReqCtl uCtl (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtKind(evtKind),
    .evtVictim(evtVictim), .snpValid(snpValid), .snpState(snpState),
    .rspIn(rspIn), .curState(lineSt), .stb(stb), .busy(busy)
  );

  cohLineReqDp uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy), .lineSt(lineSt),
    .reqOut(reqOut), .protoErr(protoErr), .wbDrop(wbDrop)
  );

  assign lineState = lineSt;
endmodule

// File: tb/cohLineReq_test.sv
module cohLineReq_test;
  import cohLineReqPkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtValid = 1'b0, evtVictim = 1'b0, snpValid = 1'b0;
  logic [2:0] evtKind = 3'd0, snpState = 3'd0;
  logic [4:0] rspIn = 5'd0;
  logic [3:0] reqOut;
  logic busy, protoErr, wbDrop;
  logic [2:0] lineState;

  int nVec = 0, nBad = 0;
  logic [3:0] expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cohLineReq uut (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtKind(evtKind),
    .evtVictim(evtVictim), .snpValid(snpValid), .snpState(snpState),
    .rspIn(rspIn), .reqOut(reqOut), .busy(busy), .lineState(lineState),
    .protoErr(protoErr), .wbDrop(wbDrop)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: every request strobe is matched against the scoreboard
  always @(negedge clk) begin
    if (rstN && reqOut !== 4'b0000) begin
      nVec++;
      if (expQ.size() == 0) begin
        nBad++;
        $display("FAIL R10 unexpected request act=%0h exp=0", reqOut);
      end else begin
        logic [3:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (reqOut !== e) begin
          nBad++;
          $display("FAIL %s request act=%0h exp=%0h", t, reqOut, e);
        end
      end
    end
  end

  task automatic evt(evtKind_e k, logic vic, logic [3:0] expReq, string tag);
    @(negedge clk);
    if (expReq != 4'b0000) begin expQ.push_back(expReq); tagQ.push_back(tag); end
    evtKind = k; evtVictim = vic; evtValid = 1'b1;
    @(negedge clk);
    evtValid = 1'b0; evtVictim = 1'b0;
  endtask

  task automatic rsp(logic [4:0] code);
    @(negedge clk); rspIn = code;
    @(negedge clk); rspIn = 5'd0;
  endtask

  task automatic snp(lineSt_e st);
    @(negedge clk); snpState = st; snpValid = 1'b1;
    @(negedge clk); snpValid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    nBad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 state", 8'(lineState), 8'h0);
    chk("R1 busy", 8'(busy), 8'h0);
    chk("R1 req", 8'(reqOut), 8'h0);
    chk("R1 err", 8'(protoErr | wbDrop), 8'h0);

    evt(EV_LOAD, 1'b0, REQ_RDS, "R2");
    chk("R10 busy after request", 8'(busy), 8'h1);
    rsp(RSP_UNIQ);
    chk("R2 unique->E", 8'(lineState), 8'h2);
    chk("R10 busy cleared", 8'(busy), 8'h0);

    evt(EV_LOAD, 1'b0, 4'b0, "R12");
    chk("R12 load hit E", 8'(lineState), 8'h2);

    evt(EV_STORE, 1'b0, 4'b0, "R5");
    chk("R5 E->M", 8'(lineState), 8'h4);
    chk("R5 not busy", 8'(busy), 8'h0);

    evt(EV_STORE, 1'b0, 4'b0, "R12");
    chk("R12 store hit M", 8'(lineState), 8'h4);

    evt(EV_LOAD, 1'b1, REQ_WB, "R8");
    chk("R8 busy on writeback", 8'(busy), 8'h1);
    rsp(RSP_WACK);
    chk("R8 wb ack->I", 8'(lineState), 8'h0);
    chk("R8 no drop", 8'(wbDrop), 8'h0);

    evt(EV_FETCH, 1'b0, REQ_RDSA, "R3");
    rsp(RSP_UNIQ);
    chk("R11 err on mismatch", 8'(protoErr), 8'h1);
    chk("R11 state kept", 8'(lineState), 8'h0);
    chk("R11 still busy", 8'(busy), 8'h1);
    rsp(RSP_SHR);
    chk("R3 fetch->S", 8'(lineState), 8'h1);
    chk("R11 err single pulse", 8'(protoErr), 8'h0);

    evt(EV_STORE, 1'b0, REQ_RDO, "R6");
    chk("R6 waits in S", 8'(lineState), 8'h1);
    evt(EV_LOAD, 1'b1, 4'b0, "R10");
    chk("R10 event ignored while busy", 8'(lineState), 8'h1);
    rsp(RSP_OAK);
    chk("R6 S upgrade->M", 8'(lineState), 8'h4);

    snp(ST_O);
    chk("R13 snoop writes O", 8'(lineState), 8'h3);
    evt(EV_ATOMIC, 1'b0, REQ_RDO, "R6");
    rsp(RSP_OAK);
    chk("R6 O upgrade->M", 8'(lineState), 8'h4);

    snp(ST_O);
    evt(EV_STORE, 1'b1, REQ_WB, "R8");
    rsp(RSP_WCAN);
    chk("R9 cancel->I", 8'(lineState), 8'h0);
    chk("R9 drop pulse", 8'(wbDrop), 8'h1);
    @(negedge clk);
    chk("R9 drop one cycle", 8'(wbDrop), 8'h0);
    repeat (4) @(negedge clk);
    chk("R9 no resend", 8'(expQ.size()), 8'h0);

    evt(EV_LOAD, 1'b0, REQ_RDS, "R2");
    rsp(RSP_SHR);
    chk("R2 shared->S", 8'(lineState), 8'h1);

    evt(EV_STORE, 1'b1, REQ_RDO, "R7");
    chk("R7 clean victim->I", 8'(lineState), 8'h0);
    chk("R7 busy", 8'(busy), 8'h1);
    rsp(RSP_UNIQ);
    chk("R7 refill->M", 8'(lineState), 8'h4);

    snp(ST_I);
    evt(EV_PREFOWN, 1'b0, REQ_RDO, "R4");
    rsp(RSP_UNIQ);
    chk("R4 prefetch miss->M", 8'(lineState), 8'h4);
    evt(EV_PREFOWN, 1'b0, 4'b0, "R12");
    chk("R12 prefetch on M", 8'(lineState), 8'h4);
    snp(ST_E);
    evt(EV_PREFOWN, 1'b0, 4'b0, "R12");
    chk("R12 prefetch on E", 8'(lineState), 8'h2);

    snp(ST_I);
    evt(EV_ATOMIC, 1'b0, REQ_RDO, "R4");
    rsp(RSP_UNIQ);
    chk("R4 atomic miss->M", 8'(lineState), 8'h4);

    rsp(RSP_OAK);
    chk("R11 idle reply err", 8'(protoErr), 8'h1);
    chk("R11 idle state kept", 8'(lineState), 8'h4);
    chk("R11 idle stays idle", 8'(busy), 8'h0);

    // closing reply and a new store in the same cycle
    snp(ST_I);
    evt(EV_LOAD, 1'b0, REQ_RDS, "R2");
    @(negedge clk);
    rspIn = RSP_SHR; evtKind = EV_STORE; evtValid = 1'b1;
    @(negedge clk);
    rspIn = 5'd0; evtValid = 1'b0;
    chk("R10 same-cycle reply wins", 8'(lineState), 8'h1);
    chk("R10 same-cycle not busy", 8'(busy), 8'h0);
    repeat (3) @(negedge clk);

    // snoop update and store on an idle line in the same cycle
    @(negedge clk);
    snpState = ST_E; snpValid = 1'b1; evtKind = EV_STORE; evtValid = 1'b1;
    @(negedge clk);
    snpValid = 1'b0; evtValid = 1'b0;
    chk("R13 snoop beats event", 8'(lineState), 8'h2);
    chk("R13 no transaction", 8'(busy), 8'h0);
    repeat (3) @(negedge clk);
    chk("R10 scoreboard drained", 8'(expQ.size()), 8'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule